// File: doc/BRIEF.md
# Two-Key Password Gate with Attempt Limiter

This block decides whether a host may read or write a protected data array. The host opens an attempt with a start pulse, which also says whether it wants read or write access. It then sends a 64-bit key as eight bytes, each marked by a valid strobe. The block holds two keys, one for read access and one for write access. It compares the incoming bytes against the key that matches the requested operation, starting with the most significant byte. A mismatch in any byte fails the whole attempt, but the block still takes in all eight bytes.

After the last byte the block raises a busy flag for a fixed verify interval, which the host polls. When busy drops, either the matching grant flag or the fail flag is set, and it stays set until the next attempt. A counter tracks consecutive failures and is cleared by any successful match. The eighth failure in a row pulses an array-clear request for one cycle, resets the counter and sets both keys back to zero. Software can load either key through an update port at any time.

Top module: `pwd_verifier`

## Requirements
- R1: After reset all four outputs (readGrant, writeGrant, failFlag, clearReq) and busy are low, and both keys are zero, so an all-zero key is accepted for either operation.
- R2: The first byte after a start pulse is compared with bits 63:56 of the selected key, and each following byte with the next lower byte; the same key sent in reverse byte order fails.
- R3: opWrite=0 selects the read key and can only set readGrant; opWrite=1 selects the write key and can only set writeGrant; a key that matches only the other operation's key sets failFlag.
- R4: The verdict is formed only after the eighth byte: a wrong first byte leaves busy and all flags low while the remaining bytes arrive.
- R5: busy is high for exactly VERIFY_CYCLES (default 2) cycles, starting in the cycle after the edge that takes the eighth byte; the grant or fail flag is set in the same cycle that busy falls.
- R6: A successful match resets the failure counter, so seven failures, a success and seven more failures produce no clear request.
- R7: The MAX_TRIES-th (default 8) consecutive failure sets clearReq for exactly one cycle together with failFlag, and both keys become zero.
- R8: updValid loads updWord into the read key when updSelWrite=0 and into the write key when updSelWrite=1.
- R9: If an update arrives on the same edge as the key wipe, the wipe wins and the update is lost.
- R10: A start pulse clears all earlier grant and fail flags; bytes that arrive without a preceding start pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Opens an attempt (ignored while busy) |
| opWrite | input | 1 | Operation requested at start: 0 read, 1 write |
| byteValid | input | 1 | byteIn holds a key byte |
| byteIn | input | 8 | Key byte, most significant first |
| updValid | input | 1 | Load a new key |
| updSelWrite | input | 1 | Key to load: 0 read, 1 write |
| updWord | input | 64 | New key value |
| readGrant | output | 1 | Read access granted |
| writeGrant | output | 1 | Write access granted |
| failFlag | output | 1 | Last attempt failed |
| clearReq | output | 1 | One-cycle request to erase the protected array |
| busy | output | 1 | Verdict pending (poll status) |

## Verification
Two functions can act on the same edge: the key wipe caused by the final allowed failure, and a key update from the update port. The bench provokes this by asserting updValid in the last busy cycle of the eighth consecutive failed attempt, so the update is sampled on the decision edge. It then checks that the update was dropped: an all-zero key must now grant both read and write access, which it would not if the new write key had been stored.

// File: rtl/pwdv_pkg.sv
package pwdv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_VERIFY = 2'd2
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cmpStart;   // load shadow from selected key, clear mismatch
    logic cmpByte;    // compare one byte and advance
    logic selWrite;   // key select at cmpStart
    logic wipe;       // zero both keys
  } pwdStrobe_t;

endpackage

// File: rtl/pwdv_datapath.sv
module pwdv_datapath
  import pwdv_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PWD_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pwdStrobe_t                    strobe,
  input  logic [BYTE_W-1:0]             byteIn,
  input  logic                          updValid,
  input  logic                          updSelWrite,
  input  logic [BYTE_W*PWD_BYTES-1:0]   updWord,
  output logic                          mismatch
);

  localparam int unsigned PWD_W  = BYTE_W * PWD_BYTES;
  localparam int unsigned N_KEYS = 2;

  logic [PWD_W-1:0] keyBank [N_KEYS];
  logic [PWD_W-1:0] shadow;
  logic             mismatchQ;

  // key storage: slot 0 read, slot 1 write
  for (genvar g = 0; g < N_KEYS; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        keyBank[g] <= '0;
      end else if (strobe.wipe) begin
        keyBank[g] <= '0;
      end else if (updValid && (updSelWrite == (g == 1))) begin
        keyBank[g] <= updWord;
      end
    end
  end

  // shadow copy shifted out MSB byte first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow    <= '0;
      mismatchQ <= 1'b0;
    end else if (strobe.cmpStart) begin
      shadow    <= strobe.selWrite ? keyBank[1] : keyBank[0];
      mismatchQ <= 1'b0;
    end else if (strobe.cmpByte) begin
      shadow    <= shadow << BYTE_W;
      mismatchQ <= mismatchQ | (byteIn != shadow[PWD_W-1 -: BYTE_W]);
    end
  end

  assign mismatch = mismatchQ;

  // R7 / R9: a wipe leaves both keys zero even with a concurrent update
  p_wipe_clears_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wipe |=> (keyBank[0] == '0 && keyBank[1] == '0));

  // R8: an update outside a wipe is stored in the selected slot
  p_update_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (updValid && !strobe.wipe) |=>
      ((($past(updSelWrite) ? keyBank[1] : keyBank[0])) == $past(updWord)));

endmodule

// File: rtl/pwdv_control.sv
module pwdv_control
  import pwdv_pkg::*;
#(
  parameter int unsigned PWD_BYTES     = 8,
  parameter int unsigned MAX_TRIES     = 8,
  parameter int unsigned VERIFY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic       opWrite,
  input  logic       byteValid,
  input  logic       mismatch,
  output pwdStrobe_t strobe,
  output logic       readGrant,
  output logic       writeGrant,
  output logic       failFlag,
  output logic       clearReq,
  output logic       busy
);

  localparam int unsigned CNT_W  = $clog2(PWD_BYTES + 1);
  localparam int unsigned WAIT_W = $clog2(VERIFY_CYCLES + 1);
  localparam int unsigned TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [CNT_W-1:0]  LAST_BYTE = CNT_W'(PWD_BYTES - 1);
  localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(VERIFY_CYCLES - 1);
  localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(MAX_TRIES - 1);

  ctlState_t        state;
  logic [CNT_W-1:0] byteCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [TRY_W-1:0] tryCnt;
  logic             opLatched;

  logic startOk, takeByte, lastByte, decide, failNow, wipeNow;

  always_comb begin
    startOk  = startPulse && (state != ST_VERIFY);
    takeByte = (state == ST_RECV) && byteValid && !startPulse;
    lastByte = takeByte && (byteCnt == LAST_BYTE);
    decide   = (state == ST_VERIFY) && (waitCnt == LAST_WAIT);
    failNow  = decide && mismatch;
    wipeNow  = failNow && (tryCnt == LAST_TRY);

    strobe.cmpStart = startOk;
    strobe.cmpByte  = takeByte;
    strobe.selWrite = opWrite;
    strobe.wipe     = wipeNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      byteCnt    <= '0;
      waitCnt    <= '0;
      tryCnt     <= '0;
      opLatched  <= 1'b0;
      readGrant  <= 1'b0;
      writeGrant <= 1'b0;
      failFlag   <= 1'b0;
      clearReq   <= 1'b0;
    end else begin
      clearReq <= 1'b0;
      if (startOk) begin
        state      <= ST_RECV;
        byteCnt    <= '0;
        opLatched  <= opWrite;
        readGrant  <= 1'b0;
        writeGrant <= 1'b0;
        failFlag   <= 1'b0;
      end else if (takeByte) begin
        byteCnt <= byteCnt + 1'b1;
        if (lastByte) begin
          state   <= ST_VERIFY;
          waitCnt <= '0;
        end
      end else if (state == ST_VERIFY) begin
        waitCnt <= waitCnt + 1'b1;
        if (decide) begin
          state <= ST_IDLE;
          if (failNow) begin
            failFlag <= 1'b1;
            clearReq <= wipeNow;
            tryCnt   <= wipeNow ? '0 : tryCnt + 1'b1;
          end else begin
            readGrant  <= !opLatched;
            writeGrant <= opLatched;
            tryCnt     <= '0;
          end
        end
      end
    end
  end

  assign busy = (state == ST_VERIFY);

  // R3: at most one verdict flag at a time
  p_one_verdict_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({readGrant, writeGrant, failFlag}));

  // R5: the verdict is present when busy falls
  p_verdict_on_fall_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (readGrant || writeGrant || failFlag));

  // R7: clear request is a single-cycle pulse
  p_clear_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> !clearReq);

  // R7: clear request only accompanies a failure
  p_clear_with_fail_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |-> failFlag);

endmodule

// File: rtl/pwd_verifier.sv
module pwd_verifier
  import pwdv_pkg::*;
#(
  parameter int unsigned BYTE_W        = 8,
  parameter int unsigned PWD_BYTES     = 8,
  parameter int unsigned MAX_TRIES     = 8,
  parameter int unsigned VERIFY_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        startPulse,
  input  logic                        opWrite,
  input  logic                        byteValid,
  input  logic [BYTE_W-1:0]           byteIn,
  input  logic                        updValid,
  input  logic                        updSelWrite,
  input  logic [BYTE_W*PWD_BYTES-1:0] updWord,
  output logic                        readGrant,
  output logic                        writeGrant,
  output logic                        failFlag,
  output logic                        clearReq,
  output logic                        busy
);

  pwdStrobe_t strobe;
  logic       mismatch;

  pwdv_control #(
    .PWD_BYTES    (PWD_BYTES),
    .MAX_TRIES    (MAX_TRIES),
    .VERIFY_CYCLES(VERIFY_CYCLES)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startPulse(startPulse),
    .opWrite   (opWrite),
    .byteValid (byteValid),
    .mismatch  (mismatch),
    .strobe    (strobe),
    .readGrant (readGrant),
    .writeGrant(writeGrant),
    .failFlag  (failFlag),
    .clearReq  (clearReq),
    .busy      (busy)
  );

  pwdv_datapath #(
    .BYTE_W   (BYTE_W),
    .PWD_BYTES(PWD_BYTES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .byteIn     (byteIn),
    .updValid   (updValid),
    .updSelWrite(updSelWrite),
    .updWord    (updWord),
    .mismatch   (mismatch)
  );

endmodule

// File: tb/pwd_verifier_tb.sv
`timescale 1ns/1ps
module pwd_verifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startPulse = 1'b0;
  logic        opWrite = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        updValid = 1'b0;
  logic        updSelWrite = 1'b0;
  logic [63:0] updWord = '0;
  logic        readGrant, writeGrant, failFlag, clearReq, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [63:0] KEY_RD = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] KEY_WR = 64'hFEDC_BA98_7654_3210;

  always #2.5 clk = ~clk;

  pwd_verifier u_dut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .opWrite(opWrite),
    .byteValid(byteValid), .byteIn(byteIn), .updValid(updValid),
    .updSelWrite(updSelWrite), .updWord(updWord), .readGrant(readGrant),
    .writeGrant(writeGrant), .failFlag(failFlag), .clearReq(clearReq),
    .busy(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // verdict flags packed as {readGrant, writeGrant, failFlag}
  function automatic logic [2:0] flags();
    return {readGrant, writeGrant, failFlag};
  endfunction

  task automatic loadKey(input bit wr, input logic [63:0] k);
    @(negedge clk);
    updValid = 1'b1; updSelWrite = wr; updWord = k;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  // start + 8 bytes; returns at the negedge after the edge taking byte 8
  task automatic sendKey(input bit wr, input logic [63:0] k);
    @(negedge clk);
    startPulse = 1'b1; opWrite = wr;
    @(negedge clk);
    startPulse = 1'b0;
    for (int i = 0; i < 8; i++) begin
      byteValid = 1'b1; byteIn = k[63-8*i -: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  // full attempt; returns at the negedge where busy has fallen
  task automatic attempt(input bit wr, input logic [63:0] k,
                         input bit upd, input logic [63:0] updK,
                         output logic [2:0] res, output logic clr);
    sendKey(wr, k);
    @(negedge clk);
    if (upd) begin
      updValid = 1'b1; updSelWrite = 1'b1; updWord = updK;
    end
    @(negedge clk);
    updValid = 1'b0;
    res = flags();
    clr = clearReq;
  endtask

  task automatic t_reset();
    logic [2:0] r; logic c;
    chk("R1", "flags after reset", {61'd0, flags()}, 64'd0);
    chk("R1", "clearReq after reset", {63'd0, clearReq}, 64'd0);
    chk("R1", "busy after reset", {63'd0, busy}, 64'd0);
    attempt(1'b0, 64'd0, 1'b0, 64'd0, r, c);
    chk("R1", "zero read key grants", {61'd0, r}, 64'b100);
    attempt(1'b1, 64'd0, 1'b0, 64'd0, r, c);
    chk("R1", "zero write key grants", {61'd0, r}, 64'b010);
  endtask

  task automatic t_keys();
    logic [2:0] r; logic c;
    loadKey(1'b0, KEY_RD);
    loadKey(1'b1, KEY_WR);
    attempt(1'b0, KEY_RD, 1'b0, 64'd0, r, c);
    chk("R8", "loaded read key grants read", {61'd0, r}, 64'b100);
    attempt(1'b1, KEY_WR, 1'b0, 64'd0, r, c);
    chk("R3", "write key grants write only", {61'd0, r}, 64'b010);
    attempt(1'b1, KEY_RD, 1'b0, 64'd0, r, c);
    chk("R3", "read key on write op fails", {61'd0, r}, 64'b001);
    attempt(1'b0, {KEY_RD[7:0], KEY_RD[15:8], KEY_RD[23:16], KEY_RD[31:24],
                   KEY_RD[39:32], KEY_RD[47:40], KEY_RD[55:48], KEY_RD[63:56]},
            1'b0, 64'd0, r, c);
    chk("R2", "byte-reversed key fails", {61'd0, r}, 64'b001);
  endtask

  task automatic t_partial();
    logic [63:0] bad = KEY_RD ^ 64'hFF00_0000_0000_0000;
    @(negedge clk);
    startPulse = 1'b1; opWrite = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
    for (int i = 0; i < 7; i++) begin
      byteValid = 1'b1; byteIn = bad[63-8*i -: 8];
      @(negedge clk);
    end
    chk("R4", "busy low before byte 8", {63'd0, busy}, 64'd0);
    chk("R4", "no verdict before byte 8", {61'd0, flags()}, 64'd0);
    byteIn = bad[7:0];
    @(negedge clk);
    byteValid = 1'b0;
    chk("R5", "busy in first verify cycle", {63'd0, busy}, 64'd1);
    chk("R5", "no verdict in first verify cycle", {61'd0, flags()}, 64'd0);
    @(negedge clk);
    chk("R5", "busy in second verify cycle", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk("R5", "busy falls after interval", {63'd0, busy}, 64'd0);
    chk("R4", "wrong first byte fails", {61'd0, flags()}, 64'b001);
  endtask

  task automatic t_stray();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteIn = KEY_RD[63-8*i -: 8];
    end
    @(negedge clk);
    byteValid = 1'b0;
    @(negedge clk);
    chk("R10", "stray bytes leave busy low", {63'd0, busy}, 64'd0);
    chk("R10", "stray bytes keep old verdict", {61'd0, flags()}, 64'b001);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R10", "start clears verdict", {61'd0, flags()}, 64'd0);
  endtask

  task automatic t_retry_reset();
    logic [2:0] r; logic c; bit anyClr = 1'b0;
    attempt(1'b0, KEY_RD, 1'b0, 64'd0, r, c);
    for (int i = 0; i < 7; i++) begin
      attempt(1'b0, 64'd5, 1'b0, 64'd0, r, c); anyClr |= c;
    end
    attempt(1'b0, KEY_RD, 1'b0, 64'd0, r, c);
    chk("R6", "success after 7 failures", {61'd0, r}, 64'b100);
    for (int i = 0; i < 7; i++) begin
      attempt(1'b0, 64'd5, 1'b0, 64'd0, r, c); anyClr |= c;
    end
    chk("R6", "no clear request after reset of count", {63'd0, anyClr}, 64'd0);
    attempt(1'b0, KEY_RD, 1'b0, 64'd0, r, c);
    chk("R6", "keys intact", {61'd0, r}, 64'b100);
  endtask

  task automatic t_wipe();
    logic [2:0] r; logic c; bit anyClr = 1'b0;
    for (int i = 0; i < 7; i++) begin
      attempt(1'b1, 64'd9, 1'b0, 64'd0, r, c); anyClr |= c;
    end
    chk("R7", "no clear before final failure", {63'd0, anyClr}, 64'd0);
    attempt(1'b1, 64'd9, 1'b1, 64'h1111_2222_3333_4444, r, c);
    chk("R7", "clearReq on eighth failure", {63'd0, c}, 64'd1);
    chk("R7", "fail flag with clear", {61'd0, r}, 64'b001);
    @(negedge clk);
    chk("R7", "clearReq one cycle", {63'd0, clearReq}, 64'd0);
    attempt(1'b0, 64'd0, 1'b0, 64'd0, r, c);
    chk("R7", "read key zeroed", {61'd0, r}, 64'b100);
    attempt(1'b1, 64'd0, 1'b0, 64'd0, r, c);
    chk("R9", "concurrent update lost, write key zero", {61'd0, r}, 64'b010);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_partial();
    t_stray();
    t_retry_reset();
    t_wipe();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

endmodule